// File: doc/BRIEF.md
# DMA Request Line Serializer

This block sits in a peripheral on a low pin count host bus. It watches a set of per-channel DMA request levels and reports every change of level to the host as a short serial message on a single active-low request wire. The wire is driven only by the peripheral, is clocked by the bus clock, and rests high whenever nothing is being sent.

Each message carries, in this order: a low start bit, the three-bit channel number sent most significant bit first, the new request level, and a high stop bit. A level of 1 asks the host for service and a level of 0 withdraws the request. Channel 4 is the channel that bus-master requests use; it is encoded like any other channel. When several channels change at once, the messages go out one after another, lowest channel number first. A power-down warning input holds back new messages until it is released.

Top module: `dma_req_serializer`

## Requirements
- R1: Out of synchronous reset (`rst` high) the serial line is high, `busy_o` and `done_o` are low, every channel's reported level is 0, and with all inputs low no message is sent.
- R2: A message lasts six clock cycles on `ldrq_n_o`: cycle 0 is 0 (start), cycles 1 to 3 hold channel bits 2, 1, 0, cycle 4 holds the new level, cycle 5 is 1 (stop).
- R3: With the serializer idle, a change on `req_i` that is present at clock edge E makes the start bit appear on the line after edge E+1.
- R4: Each change of a channel's level is reported once with the new level (1 = request asserted, 0 = withdrawn); a channel whose level matches its last reported level sends nothing.
- R5: When several channels have unreported changes, the lowest channel number is sent first, and the next start bit follows the previous stop bit with no idle cycle.
- R6: A level that changes and returns to its last reported value before its message starts produces no message.
- R7: While `pwr_dn_i` is high at a clock edge, no new message starts at that edge; a message already in progress completes, and held changes are sent after `pwr_dn_i` falls.
- R8: `busy_o` is high in every cycle of a message from the start bit through the stop bit; `done_o` is a one-cycle pulse in the cycle after each stop bit.
- R9: Channel 4 (bus-master request channel) changes are reported with channel bits 1, 0, 0 like any other channel.
- R10: Whenever `busy_o` is low the line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_CH | Per-channel DMA request levels |
| pwr_dn_i | input | 1 | Power-down warning; blocks new messages |
| ldrq_n_o | output | 1 | Active-low serial request line |
| busy_o | output | 1 | High while a message is on the line |
| done_o | output | 1 | One-cycle pulse after each stop bit |

## Verification
A level change is registered at the first clock edge, the message is launched at the second, so the start bit is due after the second edge and the stop bit five cycles later, with `done_o` one cycle after that. The bench runs a behavioural model that advances on the same edges and compares line, busy and done at every falling edge, so each result is checked in the exact cycle it is due. A bench-side receiver decodes the line into channel/level pairs, and directed cases check the order and content of those pairs for simultaneous changes, reverted changes and power-down holds, plus the two-edge start latency.

// File: rtl/ldrq_pkg.sv
package ldrq_pkg;
  localparam int CHAN_BITS  = 3;
  localparam int FRAME_BITS = CHAN_BITS + 3;
  localparam logic START_LVL = 1'b0;
  localparam logic STOP_LVL  = 1'b1;
  localparam logic IDLE_LVL  = 1'b1;

  // Bits that follow the start bit, first-sent bit in the MSB.
  function automatic logic [FRAME_BITS-2:0] frame_tail(input logic [CHAN_BITS-1:0] ch,
                                                       input logic lvl);
    return {ch, lvl, STOP_LVL};
  endfunction
endpackage

// File: rtl/ldrq_level_track.sv
module ldrq_level_track #(
  parameter int NUM_CH = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CH-1:0]              req_i,
  input  logic                           grant_i,
  input  logic [ldrq_pkg::CHAN_BITS-1:0] grant_idx_i,
  output logic [NUM_CH-1:0]              level_o,
  output logic [NUM_CH-1:0]              pending_o
);
  logic [NUM_CH-1:0] req_q;
  logic [NUM_CH-1:0] sent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      sent_q <= '0;
    end else begin
      req_q <= req_i;
      if (grant_i) sent_q[grant_idx_i] <= req_q[grant_idx_i];
    end
  end

  assign level_o   = req_q;
  assign pending_o = req_q ^ sent_q;

  // R4
  report_once_chk: assert property (@(posedge clk) disable iff (rst)
    !grant_i |=> $stable(sent_q));
endmodule

// File: rtl/ldrq_prio_pick.sv
module ldrq_prio_pick #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0]              pend_i,
  output logic                           valid_o,
  output logic [ldrq_pkg::CHAN_BITS-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        valid_o = 1'b1;
        idx_o   = ldrq_pkg::CHAN_BITS'(i);
      end
    end
  end

  always_comb begin
    if (valid_o) begin
      // R5
      pick_lowest_chk: assert (pend_i[idx_o]);
    end
  end
endmodule

// File: rtl/ldrq_frame_tx.sv
module ldrq_frame_tx
  import ldrq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic [CHAN_BITS-1:0] ch_i,
  input  logic                 lvl_i,
  output logic                 ready_o,
  output logic                 ldrq_n_o,
  output logic                 busy_o,
  output logic                 done_o
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-2:0] sh_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  busy_q, line_q, done_q;
  logic                  at_stop;

  assign at_stop = busy_q && (cnt_q == LAST_POS);
  assign ready_o = !busy_q || at_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      line_q <= IDLE_LVL;
      done_q <= 1'b0;
    end else begin
      done_q <= at_stop;
      if (load_i && ready_o) begin
        line_q <= START_LVL;
        sh_q   <= frame_tail(ch_i, lvl_i);
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (at_stop) begin
        line_q <= IDLE_LVL;
        busy_q <= 1'b0;
      end else if (busy_q) begin
        line_q <= sh_q[FRAME_BITS-2];
        sh_q   <= {sh_q[FRAME_BITS-3:0], 1'b0};
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign ldrq_n_o = line_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> ldrq_n_o);
  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && ready_o) |=> (!ldrq_n_o && busy_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/dma_req_serializer.sv
module dma_req_serializer #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              pwr_dn_i,
  output logic              ldrq_n_o,
  output logic              busy_o,
  output logic              done_o
);
  import ldrq_pkg::*;

  logic [NUM_CH-1:0]    level, pending;
  logic                 pick_vld, tx_ready, launch;
  logic [CHAN_BITS-1:0] pick_idx;

  ldrq_level_track #(.NUM_CH(NUM_CH)) track_i (
    .clk(clk), .rst(rst), .req_i(req_i),
    .grant_i(launch), .grant_idx_i(pick_idx),
    .level_o(level), .pending_o(pending)
  );

  ldrq_prio_pick #(.NUM_CH(NUM_CH)) pick_i (
    .pend_i(pending), .valid_o(pick_vld), .idx_o(pick_idx)
  );

  assign launch = pick_vld && tx_ready && !pwr_dn_i;

  ldrq_frame_tx tx_i (
    .clk(clk), .rst(rst), .load_i(launch), .ch_i(pick_idx),
    .lvl_i(level[pick_idx]), .ready_o(tx_ready),
    .ldrq_n_o(ldrq_n_o), .busy_o(busy_o), .done_o(done_o)
  );

  // R7
  pwr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_dn_i && !busy_o) |=> !busy_o);
endmodule

// File: tb/dma_req_serializer_tb_top.sv
module dma_req_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req = '0;
  logic       pwr = 1'b0;
  logic       line, busy, done;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  dma_req_serializer #(.NUM_CH(8)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .pwr_dn_i(pwr),
    .ldrq_n_o(line), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int       m_bit = -1;
  bit [5:0] m_frame;
  bit [7:0] m_req = '0, m_last = '0;
  bit       m_line = 1'b1, m_busy = 1'b0, m_done = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_bit = -1; m_req = '0; m_last = '0;
      m_line = 1'b1; m_busy = 1'b0; m_done = 1'b0;
    end else begin
      bit can_start, found;
      bit [7:0] pend;
      can_start = (m_bit < 0) || (m_bit == 5);
      m_done = (m_bit == 5);
      if (m_bit == 5) begin
        m_bit = -1; m_line = 1'b1; m_busy = 1'b0;
      end else if (m_bit >= 0) begin
        m_bit++;
        m_line = m_frame[5 - m_bit];
      end
      pend = m_req ^ m_last;
      found = 1'b0;
      if (can_start && !pwr) begin
        for (int c = 0; c < 8; c++) begin
          if (pend[c] && !found) begin
            found = 1'b1;
            m_frame = {1'b0, 3'(c), m_req[c], 1'b1};
            m_last[c] = m_req[c];
            m_bit = 0; m_line = 1'b0; m_busy = 1'b1;
          end
        end
      end
      m_req = req;
    end
  end

  always @(negedge clk) begin
    chk("R2/R10 line vs model", int'(line), int'(m_line));
    chk("R8 busy vs model", int'(busy), int'(m_busy));
    chk("R8 done vs model", int'(done), int'(m_done));
  end

  // Receiver: decodes the line into (channel, level) pairs
  int rx_ch[$];
  int rx_lv[$];
  int rx_cnt = 0;
  bit [4:0] rx_sh;
  always @(negedge clk) begin
    if (rst) rx_cnt = 0;
    else if (rx_cnt == 0) begin
      if (!line) rx_cnt = 1;
    end else begin
      rx_sh = {rx_sh[3:0], line};
      rx_cnt++;
      if (rx_cnt == 6) begin
        chk("R2 stop bit high", int'(line), 1);
        rx_ch.push_back(int'(rx_sh[4:2]));
        rx_lv.push_back(int'(rx_sh[1]));
        rx_cnt = 0;
      end
    end
  end

  task automatic exp_frame(input string tag, input int ch, input int lv);
    if (rx_ch.size() == 0) begin
      chk({tag, " frame missing"}, -1, ch);
    end else begin
      chk({tag, " channel"}, rx_ch.pop_front(), ch);
      chk({tag, " level"}, rx_lv.pop_front(), lv);
    end
  endtask

  task automatic exp_none(input string tag);
    chk({tag, " no extra frame"}, rx_ch.size(), 0);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int busy_seen;
    cycles(3);
    // R1 reset state
    chk("R1 line high in reset", int'(line), 1);
    chk("R1 busy low in reset", int'(busy), 0);
    rst = 1'b0;
    cycles(10);
    chk("R1 line idle after reset", int'(line), 1);
    chk("R1 done low after reset", int'(done), 0);
    exp_none("R1");

    // R3 latency, R2/R4 assert ch3
    req[3] = 1'b1;
    cycles(1);
    chk("R3 line still high after first edge", int'(line), 1);
    cycles(1);
    chk("R3 start bit after second edge", int'(line), 0);
    cycles(10);
    exp_frame("R4 assert ch3", 3, 1);
    exp_none("R4");

    // R4 withdraw
    req[3] = 1'b0;
    cycles(12);
    exp_frame("R4 withdraw ch3", 3, 0);
    exp_none("R4");

    // R5/R9 simultaneous changes, channel 4 included
    req[6] = 1'b1; req[1] = 1'b1; req[4] = 1'b1;
    cycles(25);
    exp_frame("R5 first lowest ch1", 1, 1);
    exp_frame("R9 bus-master ch4", 4, 1);
    exp_frame("R5 last ch6", 6, 1);
    exp_none("R5");

    // R6 reverted change
    req[0] = 1'b1;
    cycles(2);
    req[2] = 1'b1;
    cycles(2);
    req[2] = 1'b0;
    cycles(15);
    exp_frame("R6 ch0 sent", 0, 1);
    exp_none("R6 reverted ch2 silent");

    // R7 power-down holds new messages
    pwr = 1'b1;
    req[5] = 1'b1;
    busy_seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (busy) busy_seen = 1;
    end
    chk("R7 no busy while power-down", busy_seen, 0);
    exp_none("R7 held");
    pwr = 1'b0;
    cycles(12);
    exp_frame("R7 released ch5", 5, 1);
    exp_none("R7");

    // R7 frame in progress completes
    req[7] = 1'b1;
    cycles(3);
    chk("R8 busy during frame", int'(busy), 1);
    pwr = 1'b1;
    req[2] = 1'b1;
    cycles(14);
    chk("R8 idle after frame", int'(busy), 0);
    exp_frame("R7 in-progress ch7 completes", 7, 1);
    exp_none("R7 ch2 held");
    pwr = 1'b0;
    cycles(12);
    exp_frame("R7 ch2 after release", 2, 1);
    exp_none("R7");

    // R4 unchanged level sends nothing
    req[2] = 1'b1;
    cycles(10);
    exp_none("R4 no change no frame");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule